// File: doc/BRIEF.md
# Multi-group severity interrupt aggregator

The block gathers 128 interrupt sources, arranged as four groups of 32, into sticky cause latches. Each source can be made edge- or level-sensitive per bit. Software can inject causes, clear them by writing zeros, and mask them. Every latched cause feeds four separately masked OR trees. These give four severity summary lines (error, abort, fatal, log). A fifth line reports any cause that the interrupt mask leaves open.

All storage sits behind an APB slave. Group `g` occupies a 0x40-byte slice at `g*0x40`. A two-state bus sequencer has the states IDLE and ACCESS. It moves IDLE→ACCESS on a setup phase (select high, enable low). It always leaves ACCESS for IDLE after one cycle. Each transfer completes with zero wait states. An access cycle without select and enable both high writes nothing.

Top module: `sev_irq_hub`

## Requirements
- R1: After reset the cause latches read 0, the interrupt mask and all four severity masks read 0xFFFFFFFF, the edge select reads 0, the group control word reads 0x1, and all five outputs are low.
- R2: Register address = group*0x40 + offset. The offsets are: cause 0x00, inject 0x08, mask 0x10, mask-clear 0x18, status 0x20, control 0x28, error mask 0x2C, abort mask 0x30, fatal mask 0x34, log mask 0x38, edge select 0x3C.
- R3: With edge-select bit 0 (level), a cause bit is set in every cycle its input is high. It stays set after the input falls.
- R4: With edge-select bit 1 (edge), a cause bit is set only when its input goes from 0 to 1. The previous sample is 0 after reset. An input held high does not set the bit again after it is cleared.
- R5: A write to offset 0x00 clears every cause bit written as 0. Bits written as 1 are left unchanged.
- R6: When a hardware set and a software clear reach the same cause bit in one cycle, the bit ends up set.
- R7: Writing 1 to a bit of offset 0x08 sets that cause bit. Offset 0x08 reads as 0.
- R8: Offset 0x10 is a read/write interrupt mask. Writing 0 to a bit of offset 0x18 clears that mask bit, and writing 1 leaves it unchanged. Offset 0x18 reads as 0.
- R9: Offset 0x20 reads the latched cause bits. Writes to it have no effect.
- R10: Each of sev_error, sev_abort, sev_fatal and sev_log is the OR over all groups of (cause AND NOT its own mask). The four masks act independently.
- R11: irq_masked is the OR over all groups of (cause AND NOT interrupt mask).
- R12: pready is high only in the single ACCESS cycle that follows a setup phase. Every access completes in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable |
| pwrite | input | 1 | APB write (1) / read (0) |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid while pready is high |
| pready | output | 1 | APB transfer complete |
| src_in | input | 128 | interrupt sources, bit 32*g+i is group g bit i |
| irq_masked | output | 1 | any cause open under the interrupt mask |
| sev_error | output | 1 | error summary line |
| sev_abort | output | 1 | abort summary line |
| sev_fatal | output | 1 | fatal summary line |
| sev_log | output | 1 | log summary line |

## Verification
A wrong cause latch shows at the ports on the very next clock edge. Once any severity mask or the interrupt mask is open on that bit, a summary line rises or falls one cycle early or late. A later read of offset 0x00 or 0x20 returns a bit that disagrees with the input history. A corrupted mask or edge-select bit can stay hidden until a source on that bit fires. The bench therefore opens each mask before it raises the source and watches the summary lines in the cycle after the write. A sequencer stuck in ACCESS shows at once, because pready stays high on the cycle after a transfer.

// File: rtl/sev_irq_pkg.sv
package sev_irq_pkg;
    localparam logic [5:0] OFF_CAUSE = 6'h00;
    localparam logic [5:0] OFF_SET   = 6'h08;
    localparam logic [5:0] OFF_MASK  = 6'h10;
    localparam logic [5:0] OFF_MCLR  = 6'h18;
    localparam logic [5:0] OFF_STAT  = 6'h20;
    localparam logic [5:0] OFF_CTRL  = 6'h28;
    localparam logic [5:0] OFF_ERRM  = 6'h2C;
    localparam logic [5:0] OFF_ABTM  = 6'h30;
    localparam logic [5:0] OFF_FATM  = 6'h34;
    localparam logic [5:0] OFF_LOGM  = 6'h38;
    localparam logic [5:0] OFF_EDGE  = 6'h3C;

    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_ACCESS = 1'b1} bus_st_e;

    typedef struct packed {
        logic err;
        logic abt;
        logic fat;
        logic lg;
        logic irq;
    } sev_lines_t;
endpackage

// File: rtl/sev_irq_bus.sv
module sev_irq_bus
    import sev_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic pready,
    output logic wr_stb,
    output logic rd_stb
);
    bus_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:   state_d = (psel && !penable) ? ST_ACCESS : ST_IDLE;
            ST_ACCESS: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pready = 1'b0;
        wr_stb = 1'b0;
        rd_stb = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACCESS: begin
                pready = 1'b1;
                wr_stb = psel && penable && pwrite;
                rd_stb = psel && penable && !pwrite;
            end
            default: ;
        endcase
    end

    AST_PREADY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pready |=> !pready); // R12
endmodule

// File: rtl/sev_irq_group.sv
module sev_irq_group
    import sev_irq_pkg::*;
#(
    parameter int GRP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] src,
    input  logic             wr_en,
    input  logic [5:0]       off,
    input  logic [GRP_W-1:0] wdata,
    output logic [GRP_W-1:0] rdata,
    output sev_lines_t       lines
);
    localparam logic [GRP_W-1:0] ONES = '1;
    localparam logic [GRP_W-1:0] CTRL_RST = GRP_W'(1);

    logic [GRP_W-1:0] cause_q, src_q, mask_q, ctrl_q, edge_q;
    logic [GRP_W-1:0] errm_q, abtm_q, fatm_q, logm_q;
    logic [GRP_W-1:0] hw_set, sw_set, keep;

    assign hw_set = (edge_q & src & ~src_q) | (~edge_q & src);
    assign sw_set = (wr_en && off == OFF_SET) ? wdata : '0;
    assign keep   = (wr_en && off == OFF_CAUSE) ? wdata : ONES;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
            src_q   <= '0;
            mask_q  <= ONES;
            ctrl_q  <= CTRL_RST;
            edge_q  <= '0;
            errm_q  <= ONES;
            abtm_q  <= ONES;
            fatm_q  <= ONES;
            logm_q  <= ONES;
        end else begin
            src_q   <= src;
            cause_q <= (cause_q & keep) | hw_set | sw_set;
            if (wr_en) begin
                unique case (off)
                    OFF_MASK: mask_q <= wdata;
                    OFF_MCLR: mask_q <= mask_q & wdata;
                    OFF_CTRL: ctrl_q <= wdata;
                    OFF_ERRM: errm_q <= wdata;
                    OFF_ABTM: abtm_q <= wdata;
                    OFF_FATM: fatm_q <= wdata;
                    OFF_LOGM: logm_q <= wdata;
                    OFF_EDGE: edge_q <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (off)
            OFF_CAUSE, OFF_STAT: rdata = cause_q;
            OFF_MASK: rdata = mask_q;
            OFF_CTRL: rdata = ctrl_q;
            OFF_ERRM: rdata = errm_q;
            OFF_ABTM: rdata = abtm_q;
            OFF_FATM: rdata = fatm_q;
            OFF_LOGM: rdata = logm_q;
            OFF_EDGE: rdata = edge_q;
            default:  rdata = '0;
        endcase
    end

    assign lines.err = |(cause_q & ~errm_q);
    assign lines.abt = |(cause_q & ~abtm_q);
    assign lines.fat = |(cause_q & ~fatm_q);
    assign lines.lg  = |(cause_q & ~logm_q);
    assign lines.irq = |(cause_q & ~mask_q);

    AST_CAUSE_DROP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(cause_q) & ~cause_q)) |-> $past(wr_en && off == OFF_CAUSE)); // R5
    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(src & ~edge_q)) |=> (($past(src & ~edge_q) & ~cause_q) == '0)); // R3
    AST_MASK_RISE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (|(mask_q & ~$past(mask_q))) |-> $past(wr_en && off == OFF_MASK)); // R8
    AST_EDGE_HELD_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (|(edge_q & src & src_q & ~cause_q))) |=>
        (($past(edge_q & src & src_q & ~cause_q) & cause_q) == '0)); // R4
endmodule

// File: rtl/sev_irq_hub.sv
module sev_irq_hub
    import sev_irq_pkg::*;
#(
    parameter int NUM_GRP = 4,
    parameter int GRP_W   = 32,
    parameter int ADDR_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     psel,
    input  logic                     penable,
    input  logic                     pwrite,
    input  logic [ADDR_W-1:0]        paddr,
    input  logic [GRP_W-1:0]         pwdata,
    output logic [GRP_W-1:0]         prdata,
    output logic                     pready,
    input  logic [NUM_GRP*GRP_W-1:0] src_in,
    output logic                     irq_masked,
    output logic                     sev_error,
    output logic                     sev_abort,
    output logic                     sev_fatal,
    output logic                     sev_log
);
    localparam int SEL_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

    logic wr_stb, rd_stb;
    logic [SEL_W-1:0] grp_sel;
    logic [GRP_W-1:0] grp_rd [NUM_GRP];
    sev_lines_t       grp_ln [NUM_GRP];

    assign grp_sel = paddr[6 +: SEL_W];

    sev_irq_bus u_bus (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .pready(pready), .wr_stb(wr_stb), .rd_stb(rd_stb)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        sev_irq_group #(.GRP_W(GRP_W)) u_grp (
            .clk(clk), .rst_n(rst_n),
            .src(src_in[g*GRP_W +: GRP_W]),
            .wr_en(wr_stb && (grp_sel == SEL_W'(g))),
            .off(paddr[5:0]),
            .wdata(pwdata),
            .rdata(grp_rd[g]),
            .lines(grp_ln[g])
        );
    end

    always_comb begin
        prdata     = rd_stb ? grp_rd[grp_sel] : '0;
        sev_error  = 1'b0;
        sev_abort  = 1'b0;
        sev_fatal  = 1'b0;
        sev_log    = 1'b0;
        irq_masked = 1'b0;
        for (int g = 0; g < NUM_GRP; g++) begin
            sev_error  = sev_error  | grp_ln[g].err;
            sev_abort  = sev_abort  | grp_ln[g].abt;
            sev_fatal  = sev_fatal  | grp_ln[g].fat;
            sev_log    = sev_log    | grp_ln[g].lg;
            irq_masked = irq_masked | grp_ln[g].irq;
        end
    end
endmodule

// File: tb/sim_sev_irq_hub.sv
module sim_sev_irq_hub;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic pready;
    logic [127:0] src_in = '0;
    logic irq_masked, sev_error, sev_abort, sev_fatal, sev_log;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    sev_irq_hub u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .src_in(src_in), .irq_masked(irq_masked), .sev_error(sev_error),
        .sev_abort(sev_abort), .sev_fatal(sev_fatal), .sev_log(sev_log)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1; #1 d = prdata;
        chk("R12 pready in access", {31'b0, pready}, 32'h1);
        @(negedge clk); psel = 0; penable = 0;
        chk("R12 pready after access", {31'b0, pready}, 32'h0);
    endtask

    function automatic logic [31:0] lines();
        return {27'b0, sev_error, sev_abort, sev_fatal, sev_log, irq_masked};
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 outputs low", lines(), 32'h0);
        rd(8'h00, d); chk("R1 cause", d, 32'h0);
        rd(8'h10, d); chk("R1 mask", d, 32'hFFFFFFFF);
        rd(8'h28, d); chk("R1 ctrl", d, 32'h1);
        rd(8'hE8, d); chk("R1 R2 ctrl grp3", d, 32'h1);
        rd(8'h6C, d); chk("R1 R2 error mask grp1", d, 32'hFFFFFFFF);
        rd(8'hB8, d); chk("R1 R2 log mask grp2", d, 32'hFFFFFFFF);
        rd(8'h3C, d); chk("R1 edge sel", d, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        @(negedge clk); src_in[37] = 1'b1;
        @(negedge clk); @(negedge clk); src_in[37] = 1'b0;
        rd(8'h40, d); chk("R3 level set sticks", d, 32'h20);
        rd(8'h60, d); chk("R9 status shows cause", d, 32'h20);
        chk("R11 masked line low", {31'b0, irq_masked}, 32'h0);
        wr(8'h60, 32'h0);
        rd(8'h40, d); chk("R9 status write ignored", d, 32'h20);
        wr(8'h48, 32'h3);
        rd(8'h40, d); chk("R7 inject", d, 32'h23);
        rd(8'h48, d); chk("R7 inject reads 0", d, 32'h0);
        wr(8'h40, 32'hFFFFFFDE);
        rd(8'h40, d); chk("R5 write0 clears write1 keeps", d, 32'h2);
        wr(8'h40, 32'h0);
        rd(8'h40, d); chk("R5 full clear", d, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(8'hBC, 32'h1);
        @(negedge clk); src_in[64] = 1'b1;
        @(negedge clk);
        rd(8'h80, d); chk("R4 edge sets", d, 32'h1);
        wr(8'h80, 32'h0);
        @(negedge clk); @(negedge clk);
        rd(8'h80, d); chk("R4 held high no reset", d, 32'h0);
        src_in[64] = 1'b0; @(negedge clk); src_in[64] = 1'b1; @(negedge clk);
        rd(8'h80, d); chk("R4 new rise sets", d, 32'h1);
        src_in[64] = 1'b0;
        wr(8'h80, 32'h0);
    endtask

    task automatic t_setwins();
        logic [31:0] d;
        @(negedge clk); src_in[7] = 1'b1;
        wr(8'h00, 32'h0);
        src_in[7] = 1'b0;
        rd(8'h00, d); chk("R6 set beats clear", d, 32'h80);
        wr(8'h00, 32'h0);
        rd(8'h00, d); chk("R6 clear after source low", d, 32'h0);
    endtask

    task automatic t_masks();
        logic [31:0] d;
        wr(8'hD8, 32'hFFFFFFF7);
        rd(8'hD0, d); chk("R8 side door clears one bit", d, 32'hFFFFFFF7);
        rd(8'hD8, d); chk("R8 side door reads 0", d, 32'h0);
        wr(8'hC8, 32'h8);
        chk("R11 R10 irq only", lines(), 32'h01);
        wr(8'hEC, 32'hFFFFFFF7);
        chk("R10 error only", lines(), 32'h11);
        wr(8'hF4, 32'hFFFFFFF7);
        chk("R10 error and fatal", lines(), 32'h15);
        wr(8'hD0, 32'hFFFFFFFF);
        chk("R8 R11 remasked", lines(), 32'h14);
        wr(8'hC0, 32'h0);
        chk("R10 lines drop on clear", lines(), 32'h0);
        wr(8'h30, 32'hFFFFFFFE);
        wr(8'h38, 32'hFFFFFFFE);
        wr(8'h08, 32'h1);
        chk("R10 abort and log via group 0", lines(), 32'h0A);
        wr(8'h00, 32'h0);
        chk("R10 all low", lines(), 32'h0);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level();
        t_edge();
        t_setwins();
        t_masks();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule